// File: doc/BRIEF.md
# Descriptor Table Register Loader

This block carries out the two privileged instructions that set the base and limit of the global descriptor table register and the interrupt descriptor table register. When an instruction is offered, the block decodes the escape byte, the group byte and the ModRM byte. From these it picks the target table. It then runs a fixed ladder of checks built from the processor mode, the current privilege level, a lock-prefix flag and the address fault flags that the address unit supplies.

If a check fails, the block reports a two-bit exception code for one cycle and leaves both tables untouched. If every check passes, it asks for the memory operand one byte per cycle over a read port with a valid handshake. It places each byte little-endian into an operand register and writes the target table in a single cycle, with a done pulse.

The operand length and the treatment of the base depend on the mode and the operand size. In 64-bit mode the operand is ten bytes and the base is eight bytes wide. In the legacy modes the operand is six bytes. With a 16-bit operand size, the top byte of the 32-bit base is cleared. An abort input drops an operand that is only partly gathered.

Top module: `dtr_loader`

## Requirements
- R1: An instruction is recognised only when `op0` is 0x0F, `op1` is 0x01 and ModRM bits 5:3 are 2 (global table) or 3 (interrupt table). Any other combination is ignored: no read request, no done and no exception.
- R2: A register operand (ModRM bits 7:6 equal to 3) or `lock_pfx` high raises exception code 1 (invalid opcode) in every mode, ahead of every other check.
- R3: After R2, mode 2 (virtual-8086) raises code 2 (general protection). So does a `cpl` other than 0 in mode 1 (protected) or mode 3 (64-bit). In mode 0 (real) the privilege level is not checked.
- R4: After R3, address faults apply. In mode 3, `addr_canon` low raises code 3 (stack fault) when `use_ss` is high and code 2 otherwise, and the segment flags are ignored. In modes 0 and 1, `seg_limit_fault` raises code 3 with `use_ss` and code 2 without it. In mode 1 only, `null_sel_fault` then raises code 2.
- R5: A faulting instruction sets `exc_valid` for exactly the cycle after `start`, with the code on `exc_code`. It never raises `rd_req` and leaves all four table outputs unchanged.
- R6: In modes 0 to 2 with `opsize32` high, six bytes are read. The limit is bytes 1:0 and the base is bytes 5:2, zero-extended to 64 bits.
- R7: In modes 0 to 2 with `opsize32` low, six bytes are still read, but byte 5 is ignored and base bits 63:24 are zero.
- R8: In mode 3, ten bytes are read whatever `opsize32` says. The limit is bytes 1:0 and the base is bytes 9:2.
- R9: `rd_req` is high from the cycle after an accepted `start` until the last byte is taken. A byte is taken only on an edge where `rd_req` and `rd_valid` are both high, so any number of stall cycles is allowed.
- R10: `done` is a one-cycle pulse in the first cycle that shows the new table value. Table outputs change in no other cycle, and the table that was not selected keeps its value.
- R11: `abort` high on an edge while bytes are being gathered returns the block to idle with no table write and no done. The next instruction then loads normally.
- R12: Reset sets both limits to 0xFFFF and both bases to 0, and holds `rd_req`, `done`, `exc_valid` and `busy` low.
- R13: While `busy` is high, a `start` is ignored and the operand in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction offered this cycle |
| op0 | input | 8 | First opcode byte |
| op1 | input | 8 | Second opcode byte |
| modrm | input | 8 | ModRM byte |
| mode | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 64-bit |
| opsize32 | input | 1 | Operand-size attribute is 32 bits |
| cpl | input | 2 | Current privilege level |
| lock_pfx | input | 1 | Lock prefix present |
| addr_canon | input | 1 | Operand address is canonical |
| seg_limit_fault | input | 1 | Operand address exceeds its segment limit |
| null_sel_fault | input | 1 | Data segment used holds a null selector |
| use_ss | input | 1 | Access goes through the stack segment |
| abort | input | 1 | Drop the instruction in progress |
| rd_req | output | 1 | Block wants the next operand byte |
| rd_valid | input | 1 | `rd_data` holds a valid byte |
| rd_data | input | 8 | Operand byte |
| done | output | 1 | Table written (one-cycle pulse) |
| exc_valid | output | 1 | Exception raised (one-cycle pulse) |
| exc_code | output | 2 | 1 invalid opcode, 2 general protection, 3 stack fault |
| busy | output | 1 | Operand gathering in progress |
| gdt_limit | output | 16 | Global table limit |
| gdt_base | output | 64 | Global table base |
| idt_limit | output | 16 | Interrupt table limit |
| idt_base | output | 64 | Interrupt table base |

## Verification
The hardest situation to reach is one where several events coincide. One case is an abort that arrives on the same edge as a valid byte, with part of the operand already held. Another is a second `start` offered in the middle of a stalled gather. The driver reaches both by counting cycles after the accepted `start`: it raises `abort` together with `rd_valid` after a chosen number of bytes, and it raises a conflicting `start` on the third cycle of a gather that has stalls inserted. The check ladder is covered with flag combinations that make two faults true at once, so that only the priority order decides the code.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

   typedef enum logic [1:0] {
      MODE_REAL = 2'd0,
      MODE_PROT = 2'd1,
      MODE_V86  = 2'd2,
      MODE_LONG = 2'd3
   } cpu_mode_e;

   typedef enum logic [1:0] {
      EXC_NONE = 2'd0,
      EXC_UD   = 2'd1,
      EXC_GP   = 2'd2,
      EXC_SS   = 2'd3
   } exc_e;

   localparam logic [7:0] OPC_ESC = 8'h0F;
   localparam logic [7:0] OPC_GRP = 8'h01;
   localparam logic [2:0] REG_GDT = 3'd2;
   localparam logic [2:0] REG_IDT = 3'd3;
   localparam int         BYTE_W  = 8;

   typedef struct packed {
      logic is_idt;
      logic long_md;
      logic half_base;
   } ctx_t;

endpackage

// File: rtl/dtr_check.sv
module dtr_check
   import dtr_pkg::*;
(
   input  logic [7:0] op0,
   input  logic [7:0] op1,
   input  logic [7:0] modrm,
   input  logic [1:0] mode,
   input  logic [1:0] cpl,
   input  logic       lock_pfx,
   input  logic       addr_canon,
   input  logic       seg_limit_fault,
   input  logic       null_sel_fault,
   input  logic       use_ss,
   output logic       hit,
   output logic       is_idt,
   output exc_e       fault
);

   logic [2:0] reg_f;
   logic       bad_form;
   logic       bad_priv;
   exc_e       seg_code;

   assign reg_f    = modrm[5:3];
   assign hit      = (op0 == OPC_ESC) && (op1 == OPC_GRP) &&
                     ((reg_f == REG_GDT) || (reg_f == REG_IDT));
   assign is_idt   = (reg_f == REG_IDT);
   assign bad_form = lock_pfx || (modrm[7:6] == 2'b11);
   assign bad_priv = (mode == MODE_V86) ||
                     ((mode != MODE_REAL) && (cpl != 2'd0));
   assign seg_code = use_ss ? EXC_SS : EXC_GP;

   always_comb begin
      fault = EXC_NONE;
      if (bad_form) begin
         fault = EXC_UD;
      end else if (bad_priv) begin
         fault = EXC_GP;
      end else if (mode == MODE_LONG) begin
         if (!addr_canon) fault = seg_code;
      end else if (seg_limit_fault) begin
         fault = seg_code;
      end else if ((mode == MODE_PROT) && null_sel_fault) begin
         fault = EXC_GP;
      end
   end

endmodule

// File: rtl/dtr_gather.sv
module dtr_gather #(
   parameter int LONG_BYTES = 10,
   parameter int LEG_BYTES  = 6,
   localparam int OPER_W    = LONG_BYTES * dtr_pkg::BYTE_W,
   localparam int CNT_W     = $clog2(LONG_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              long_md,
   input  logic              abort,
   input  logic              rd_valid,
   input  logic [7:0]        rd_data,
   output logic              rd_req,
   output logic              busy,
   output logic              commit,
   output logic [OPER_W-1:0] operand
);

   localparam logic [CNT_W-1:0] LAST_LONG = CNT_W'(LONG_BYTES - 1);
   localparam logic [CNT_W-1:0] LAST_LEG  = CNT_W'(LEG_BYTES - 1);

   logic              active;
   logic              len_long;
   logic [CNT_W-1:0]  cnt;
   logic [OPER_W-1:0] sh;
   logic [OPER_W-1:0] nxt;
   logic              take;
   logic              last;

   assign take   = active && rd_valid && !abort;
   assign last   = take && (cnt == (len_long ? LAST_LONG : LAST_LEG));
   assign rd_req = active;
   assign busy   = active;
   assign commit = last;

   always_comb begin
      nxt = sh;
      for (int i = 0; i < LONG_BYTES; i++) begin
         if (take && (cnt == CNT_W'(i))) nxt[i*dtr_pkg::BYTE_W +: dtr_pkg::BYTE_W] = rd_data;
      end
   end

   assign operand = nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         len_long <= 1'b0;
         cnt      <= '0;
         sh       <= '0;
      end else if (abort) begin
         active <= 1'b0;
         cnt    <= '0;
         sh     <= '0;
      end else if (launch) begin
         active   <= 1'b1;
         len_long <= long_md;
         cnt      <= '0;
         sh       <= '0;
      end else if (take) begin
         sh  <= nxt;
         cnt <= cnt + 1'b1;
         if (last) active <= 1'b0;
      end
   end

endmodule

// File: rtl/dtr_tables.sv
module dtr_tables #(
   parameter int              LIMIT_W   = 16,
   parameter int              BASE_W    = 64,
   parameter int              NUM_TBL   = 2,
   parameter logic [LIMIT_W-1:0] RST_LIMIT = '1,
   localparam int             OPER_W     = LIMIT_W + BASE_W,
   localparam int             LEG_BASE_W = 32,
   localparam int             SEL_W      = (NUM_TBL > 1) ? $clog2(NUM_TBL) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr,
   input  logic [SEL_W-1:0]                 sel,
   input  logic                             long_md,
   input  logic                             half_base,
   input  logic [OPER_W-1:0]                operand,
   output logic [NUM_TBL-1:0][LIMIT_W-1:0]  lim_o,
   output logic [NUM_TBL-1:0][BASE_W-1:0]   base_o
);

   logic [LEG_BASE_W-1:0] leg_raw;
   logic [LEG_BASE_W-1:0] leg_masked;
   logic [BASE_W-1:0]     leg_base;
   logic [BASE_W-1:0]     new_base;
   logic [LIMIT_W-1:0]    new_lim;

   assign new_lim    = operand[LIMIT_W-1:0];
   assign leg_raw    = operand[LIMIT_W +: LEG_BASE_W];
   assign leg_masked = half_base ? {8'h00, leg_raw[LEG_BASE_W-9:0]} : leg_raw;

   generate
      if (BASE_W > LEG_BASE_W) begin : g_ext
         assign leg_base = {{(BASE_W-LEG_BASE_W){1'b0}}, leg_masked};
      end else begin : g_same
         assign leg_base = leg_masked;
      end
   endgenerate

   assign new_base = long_md ? operand[LIMIT_W +: BASE_W] : leg_base;

   generate
      for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lim_o[g]  <= RST_LIMIT;
               base_o[g] <= '0;
            end else if (wr && (sel == SEL_W'(g))) begin
               lim_o[g]  <= new_lim;
               base_o[g] <= new_base;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dtr_loader.sv
module dtr_loader
   import dtr_pkg::*;
#(
   parameter int                 LIMIT_W   = 16,
   parameter int                 BASE_W    = 64,
   parameter logic [LIMIT_W-1:0] RST_LIMIT = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [7:0]         op0,
   input  logic [7:0]         op1,
   input  logic [7:0]         modrm,
   input  logic [1:0]         mode,
   input  logic               opsize32,
   input  logic [1:0]         cpl,
   input  logic               lock_pfx,
   input  logic               addr_canon,
   input  logic               seg_limit_fault,
   input  logic               null_sel_fault,
   input  logic               use_ss,
   input  logic               abort,
   output logic               rd_req,
   input  logic               rd_valid,
   input  logic [7:0]         rd_data,
   output logic               done,
   output logic               exc_valid,
   output logic [1:0]         exc_code,
   output logic               busy,
   output logic [LIMIT_W-1:0] gdt_limit,
   output logic [BASE_W-1:0]  gdt_base,
   output logic [LIMIT_W-1:0] idt_limit,
   output logic [BASE_W-1:0]  idt_base
);

   localparam int LEG_BASE_W = 32;
   localparam int NUM_TBL    = 2;
   localparam int LONG_BYTES = (LIMIT_W + BASE_W) / BYTE_W;
   localparam int LEG_BYTES  = (LIMIT_W + LEG_BASE_W) / BYTE_W;
   localparam int OPER_W     = LONG_BYTES * BYTE_W;

   generate
      if ((LIMIT_W % BYTE_W) != 0 || (BASE_W % BYTE_W) != 0 || BASE_W < LEG_BASE_W) begin : g_bad_cfg
         $error("dtr_loader: widths must be whole bytes and BASE_W at least 32");
      end
   endgenerate

   logic  hit;
   logic  sel_idt;
   exc_e  fault;
   logic  accept;
   logic  launch;
   logic  commit;
   ctx_t  ctx;
   logic [OPER_W-1:0] operand;
   logic [NUM_TBL-1:0][LIMIT_W-1:0] lim;
   logic [NUM_TBL-1:0][BASE_W-1:0]  base;

   dtr_check u_check (
      .op0             (op0),
      .op1             (op1),
      .modrm           (modrm),
      .mode            (mode),
      .cpl             (cpl),
      .lock_pfx        (lock_pfx),
      .addr_canon      (addr_canon),
      .seg_limit_fault (seg_limit_fault),
      .null_sel_fault  (null_sel_fault),
      .use_ss          (use_ss),
      .hit             (hit),
      .is_idt          (sel_idt),
      .fault           (fault)
   );

   assign accept = start && !busy && hit;
   assign launch = accept && (fault == EXC_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctx       <= '0;
         exc_valid <= 1'b0;
         exc_code  <= EXC_NONE;
         done      <= 1'b0;
      end else begin
         exc_valid <= accept && (fault != EXC_NONE);
         exc_code  <= accept ? fault : EXC_NONE;
         done      <= commit;
         if (launch) begin
            ctx.is_idt    <= sel_idt;
            ctx.long_md   <= (mode == MODE_LONG);
            ctx.half_base <= !opsize32;
         end
      end
   end

   dtr_gather #(
      .LONG_BYTES (LONG_BYTES),
      .LEG_BYTES  (LEG_BYTES)
   ) u_gather (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .long_md  (mode == MODE_LONG),
      .abort    (abort),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .rd_req   (rd_req),
      .busy     (busy),
      .commit   (commit),
      .operand  (operand)
   );

   dtr_tables #(
      .LIMIT_W   (LIMIT_W),
      .BASE_W    (BASE_W),
      .NUM_TBL   (NUM_TBL),
      .RST_LIMIT (RST_LIMIT)
   ) u_tables (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (commit),
      .sel       (ctx.is_idt),
      .long_md   (ctx.long_md),
      .half_base (ctx.half_base),
      .operand   (operand),
      .lim_o     (lim),
      .base_o    (base)
   );

   assign gdt_limit = lim[0];
   assign gdt_base  = base[0];
   assign idt_limit = lim[1];
   assign idt_base  = base[1];

endmodule

// File: rtl/dtr_loader_chk.sv
module dtr_loader_chk #(
   parameter int LIMIT_W = 16,
   parameter int BASE_W  = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic [7:0]         modrm,
   input logic [1:0]         mode,
   input logic               lock_pfx,
   input logic               abort,
   input logic               rd_req,
   input logic               rd_valid,
   input logic               done,
   input logic               exc_valid,
   input logic [1:0]         exc_code,
   input logic [LIMIT_W-1:0] gdt_limit,
   input logic [BASE_W-1:0]  gdt_base,
   input logic [LIMIT_W-1:0] idt_limit,
   input logic [BASE_W-1:0]  idt_base
);

   assert_ud_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid && ($past(lock_pfx) || ($past(modrm[7:6]) == 2'b11)) |-> exc_code == 2'd1);

   assert_v86_gp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid && ($past(mode) == 2'd2) && !$past(lock_pfx) && ($past(modrm[7:6]) != 2'b11)
      |-> exc_code == 2'd2);

   assert_exc_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> !rd_req && !done && (exc_code != 2'd0));

   assert_req_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_valid && !abort |=> rd_req);

   assert_tables_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(gdt_limit) && $stable(gdt_base) && $stable(idt_limit) && $stable(idt_base));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(abort) |-> !rd_req && !done);

endmodule

bind dtr_loader dtr_loader_chk #(.LIMIT_W(LIMIT_W), .BASE_W(BASE_W)) u_chk (.*);

// File: tb/test_dtr_loader.sv
`timescale 1ns/1ps
module test_dtr_loader;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 0, opsize32 = 0, lock_pfx = 0, addr_canon = 1;
   logic        seg_limit_fault = 0, null_sel_fault = 0, use_ss = 0, abort = 0;
   logic [7:0]  op0 = 0, op1 = 0, modrm = 0, rd_data = 0;
   logic [1:0]  mode = 0, cpl = 0;
   logic        rd_valid = 0;
   logic        rd_req, done, exc_valid, busy;
   logic [1:0]  exc_code;
   logic [15:0] gdt_limit, idt_limit;
   logic [63:0] gdt_base, idt_base;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   typedef struct {
      bit          is_exc;
      logic [1:0]  code;
      string       tag;
      logic [15:0] gl;
      logic [63:0] gb;
      logic [15:0] il;
      logic [63:0] ib;
   } exp_t;

   exp_t sbq[$];
   logic [15:0] m_gl = 16'hFFFF, m_il = 16'hFFFF;
   logic [63:0] m_gb = '0, m_ib = '0;

   always #2 clk = ~clk;

   dtr_loader i_dtr_loader (.*);

   task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (done || exc_valid)) begin
         if (sbq.size() == 0) begin
            check("R5", "unexpected event", {62'd0, done, exc_valid}, 64'd0);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            check(e.tag, "exc_valid", exc_valid, e.is_exc);
            check(e.tag, "done", done, !e.is_exc);
            if (e.is_exc) check(e.tag, "exc_code", exc_code, e.code);
            check(e.tag, "gdt_limit", gdt_limit, e.gl);
            check(e.tag, "gdt_base", gdt_base, e.gb);
            check(e.tag, "idt_limit", idt_limit, e.il);
            check(e.tag, "idt_base", idt_base, e.ib);
         end
      end
   end

   function automatic logic [1:0] exp_fault(logic [7:0] mr, logic [1:0] md, logic [1:0] pl,
                                            bit lk, bit canon, bit segf, bit nullf, bit ss);
      if (lk || mr[7:6] == 2'b11) return 2'd1;
      if (md == 2'd2 || (md != 2'd0 && pl != 2'd0)) return 2'd2;
      if (md == 2'd3) return canon ? 2'd0 : (ss ? 2'd3 : 2'd2);
      if (segf) return ss ? 2'd3 : 2'd2;
      if (md == 2'd1 && nullf) return 2'd2;
      return 2'd0;
   endfunction

   task automatic issue(input logic [7:0] o0, input logic [7:0] o1, input logic [7:0] mr,
                        input logic [1:0] md, input bit sz32, input logic [1:0] pl,
                        input bit lk, input bit canon, input bit segf, input bit nullf,
                        input bit ss, input logic [7:0] seed, input bit stall, input bit poke,
                        input string tag);
      logic [7:0]  b [10];
      bit          is_hit;
      logic [1:0]  f;
      int          n;
      bit          req_ok;
      exp_t        e;
      for (int i = 0; i < 10; i++) b[i] = 8'(seed + i * 37 + 5);
      @(negedge clk);
      op0 = o0; op1 = o1; modrm = mr; mode = md; opsize32 = sz32; cpl = pl;
      lock_pfx = lk; addr_canon = canon; seg_limit_fault = segf; null_sel_fault = nullf;
      use_ss = ss; start = 1;
      is_hit = (o0 == 8'h0F) && (o1 == 8'h01) && (mr[5:3] == 3'd2 || mr[5:3] == 3'd3);
      f = exp_fault(mr, md, pl, lk, canon, segf, nullf, ss);
      if (is_hit) begin
         e.tag = tag;
         e.is_exc = (f != 2'd0);
         e.code = f;
         if (f == 2'd0) begin
            logic [15:0] lim;
            logic [63:0] bs;
            lim = {b[1], b[0]};
            if (md == 2'd3) bs = {b[9], b[8], b[7], b[6], b[5], b[4], b[3], b[2]};
            else if (sz32) bs = {32'd0, b[5], b[4], b[3], b[2]};
            else bs = {40'd0, b[4], b[3], b[2]};
            if (mr[5:3] == 3'd3) begin m_il = lim; m_ib = bs; end
            else begin m_gl = lim; m_gb = bs; end
         end
         e.gl = m_gl; e.gb = m_gb; e.il = m_il; e.ib = m_ib;
         sbq.push_back(e);
      end
      @(negedge clk);
      start = 0;
      if (!is_hit) begin
         for (int k = 0; k < 3; k++) begin
            check("R1", "rd_req on ignored opcode", rd_req, 1'b0);
            @(negedge clk);
         end
      end else if (f != 2'd0) begin
         check(tag, "rd_req on fault", rd_req, 1'b0);
         @(negedge clk);
         check(tag, "rd_req after fault", rd_req, 1'b0);
      end else begin
         n = (md == 2'd3) ? 10 : 6;
         req_ok = 1;
         for (int i = 0, k = 0; i < n; k++) begin
            if (!rd_req) req_ok = 0;
            rd_valid = !(stall && (k % 3 == 1));
            rd_data = b[i];
            if (poke && k == 2) begin
               start = 1; modrm = {mr[7:6], (mr[5:3] == 3'd2) ? 3'd3 : 3'd2, mr[2:0]};
            end else begin
               start = 0;
            end
            @(negedge clk);
            if (rd_valid) i++;
         end
         rd_valid = 0;
         start = 0;
         check(poke ? "R13" : "R9", "rd_req during gather", req_ok, 1'b1);
         check("R9", "rd_req after last byte", rd_req, 1'b0);
      end
   endtask

   task automatic issue_abort(input int nb);
      @(negedge clk);
      op0 = 8'h0F; op1 = 8'h01; modrm = 8'h10; mode = 2'd1; opsize32 = 1; cpl = 0;
      lock_pfx = 0; addr_canon = 1; seg_limit_fault = 0; null_sel_fault = 0; use_ss = 0;
      start = 1;
      @(negedge clk);
      start = 0;
      for (int i = 0; i < nb; i++) begin
         rd_valid = 1; rd_data = 8'(8'hA0 + i);
         @(negedge clk);
      end
      abort = 1; rd_valid = 1; rd_data = 8'hEE;
      @(negedge clk);
      abort = 0; rd_valid = 0;
      check("R11", "rd_req after abort", rd_req, 1'b0);
      check("R11", "busy after abort", busy, 1'b0);
      repeat (3) @(negedge clk);
      check("R11", "gdt_limit kept", gdt_limit, m_gl);
      check("R11", "gdt_base kept", gdt_base, m_gb);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      check("R9", "watchdog expired", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R12", "gdt_limit reset", gdt_limit, 16'hFFFF);
      check("R12", "idt_limit reset", idt_limit, 16'hFFFF);
      check("R12", "gdt_base reset", gdt_base, 64'd0);
      check("R12", "idt_base reset", idt_base, 64'd0);
      check("R12", "idle outputs", {rd_req, done, exc_valid, busy}, 4'b0);
      rst_n = 1;
      // o0 o1 modrm mode sz32 cpl lock canon segf null ss seed stall poke tag
      issue(8'h0F, 8'h01, 8'h10, 2'd1, 1, 0, 0, 1, 0, 0, 0, 8'h11, 0, 0, "R6");
      issue(8'h0F, 8'h01, 8'h1E, 2'd1, 0, 0, 0, 1, 0, 0, 0, 8'h42, 1, 0, "R7");
      issue(8'h0F, 8'h01, 8'h14, 2'd3, 0, 0, 0, 1, 0, 0, 0, 8'h77, 0, 0, "R8");
      issue(8'h0F, 8'h01, 8'h58, 2'd3, 1, 0, 0, 1, 0, 0, 0, 8'h93, 1, 0, "R8");
      issue(8'h0F, 8'h01, 8'h10, 2'd1, 1, 3, 1, 0, 1, 0, 0, 8'h01, 0, 0, "R2");
      issue(8'h0F, 8'h01, 8'hD8, 2'd0, 1, 0, 0, 1, 0, 0, 0, 8'h02, 0, 0, "R2");
      issue(8'h0F, 8'h01, 8'h10, 2'd1, 1, 3, 0, 1, 1, 0, 1, 8'h03, 0, 0, "R3");
      issue(8'h0F, 8'h01, 8'h18, 2'd2, 1, 0, 0, 1, 0, 0, 0, 8'h04, 0, 0, "R3");
      issue(8'h0F, 8'h01, 8'h18, 2'd3, 1, 1, 0, 0, 0, 0, 1, 8'h05, 0, 0, "R3");
      issue(8'h0F, 8'h01, 8'h18, 2'd0, 1, 3, 0, 1, 0, 1, 0, 8'h36, 0, 0, "R3");
      issue(8'h0F, 8'h01, 8'h10, 2'd3, 1, 0, 0, 0, 0, 0, 1, 8'h06, 0, 0, "R4");
      issue(8'h0F, 8'h01, 8'h10, 2'd3, 1, 0, 0, 0, 1, 1, 0, 8'h07, 0, 0, "R4");
      issue(8'h0F, 8'h01, 8'h18, 2'd1, 1, 0, 0, 1, 0, 1, 0, 8'h08, 0, 0, "R4");
      issue(8'h0F, 8'h01, 8'h18, 2'd0, 0, 0, 0, 1, 1, 0, 1, 8'h09, 0, 0, "R4");
      issue(8'h0F, 8'h01, 8'h10, 2'd1, 1, 0, 0, 1, 1, 1, 0, 8'h0A, 0, 0, "R4");
      issue(8'h0F, 8'h01, 8'h18, 2'd3, 0, 0, 0, 1, 1, 1, 1, 8'hC4, 0, 0, "R4");
      issue(8'h0F, 8'h00, 8'h10, 2'd1, 1, 0, 0, 1, 0, 0, 0, 8'h0B, 0, 0, "R1");
      issue(8'h0F, 8'h01, 8'h08, 2'd1, 1, 0, 0, 1, 0, 0, 0, 8'h0C, 0, 0, "R1");
      issue_abort(3);
      issue(8'h0F, 8'h01, 8'h10, 2'd0, 1, 0, 0, 1, 0, 0, 0, 8'h5D, 0, 0, "R11");
      issue(8'h0F, 8'h01, 8'h18, 2'd1, 1, 0, 0, 1, 0, 0, 0, 8'hE1, 1, 1, "R13");
      issue(8'h0F, 8'h01, 8'h10, 2'd3, 1, 0, 0, 1, 0, 0, 0, 8'h6B, 1, 1, "R10");
      repeat (5) @(negedge clk);
      check("R10", "all results seen", sbq.size(), 0);
      finish_run();
   end

endmodule